// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a single-bit stream by a programmable number of clock cycles. The delay is built from a series of shift-register stages whose lengths are powers of two. Each stage is either switched into the path or bypassed under one bit of an unsigned control word, so the programmable delay equals the value of that word. One clock cycle is one delay unit, and a fixed output register adds one more cycle that the control word does not count.

The control word passes through a holding register. While the hold input is low, the register takes a new word on every clock. While the hold input is high, it keeps its value. Two override inputs sit in front of the stage chain. The minimum override forces zero delay and wipes the held word. The maximum override selects every weighted stage plus one extra single-cycle stage, which gives a delay one unit past the largest value the word can encode. An active-low enable either passes the delayed stream to the output or holds the output low.

A typical use is to align a data or strobe signal against another path whose latency is known only at run time. Software or strapping logic writes the delay once and then freezes it with the hold input.

Top module: `dly_line_top`

## Requirements
- R1: With no override active and the output enabled, dataOut equals the dataIn value from D+1 cycles earlier. D is the held control word read as an unsigned number from 0 to 2^STAGES-1, and the extra cycle is the output register.
- R2: Control bit k switches in a stage of 2^k cycles, and the stage delays add up. For example, with STAGES=4, word 4'b1010 gives D=10.
- R3: While loadHold is 0, the held word takes ctrlWord on every clock edge. While loadHold is 1, the held word keeps its value and changes to ctrlWord have no effect on the delay.
- R4: While forceMin is 1, D is 0. forceMin also clears the held word, so when forceMin falls with loadHold at 1, D stays 0.
- R5: While forceMax is 1 and forceMin is 0, D is 2^STAGES. This is every weighted stage plus one extra single-cycle stage, whatever ctrlWord or the held word contains.
- R6: When forceMin and forceMax are both 1, forceMin wins and D is 0.
- R7: While enN is 1, dataOut is 0 from the next clock edge on. While enN is 0, dataOut follows the delayed stream.
- R8: A synchronous active-high rst clears every stage, the output register and the held word. dataOut is 0 during reset, and after reset with loadHold held at 1, D is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one delay unit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| dataIn | input | 1 | Stream to be delayed |
| ctrlWord | input | STAGES | Requested delay in cycles |
| loadHold | input | 1 | 0: take ctrlWord each clock; 1: hold the last word |
| forceMin | input | 1 | Force zero delay and clear the held word |
| forceMax | input | 1 | Force maximum delay, 2^STAGES |
| enN | input | 1 | Active-low output enable; 1 holds dataOut low |
| dataOut | output | 1 | Delayed stream, registered |

## Verification
The bench builds the block with STAGES=4, so the chain is 16 cycles long including the extra stage. At that size, every one of the 16 control words can be swept with random data, and each sweep finishes within a few dozen cycles. The same small chain lets the bench cover both overrides, their priority, the hold and clear interplay of the held word, and the enable, with the expected bit taken from a short history buffer that is indexed by the arithmetic delay. Each check waits until twice the chain length has passed after any control change, so bits left over from an earlier setting cannot mask an error.

// File: rtl/dly_pkg.sv
package dly_pkg;
  // Scalar strobes passed from the control to the datapath
  typedef struct packed {
    logic extraOn;  // switch in the extra single-cycle stage
    logic outEn;    // pass the delayed stream to the output
  } dlyStrobe_t;
endpackage

// File: rtl/dly_stage.sv
module dly_stage #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] sr;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[DEPTH-2:0], din};
      end
    end
  endgenerate

  // Bypass mux: the stage adds DEPTH cycles only when taken
  assign dout = take ? sr[DEPTH-1] : din;
endmodule

// File: rtl/dly_ctrl.sv
module dly_ctrl
  import dly_pkg::*;
#(
  parameter int STAGES = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] ctrlWord,
  input  logic              loadHold,
  input  logic              forceMin,
  input  logic              forceMax,
  input  logic              enN,
  output logic [STAGES-1:0] takeMask,
  output dlyStrobe_t        strobe
);
  logic [STAGES-1:0] heldWord;

  // Holding register: follows the word while open, keeps it while closed
  always_ff @(posedge clk) begin
    if (rst)            heldWord <= '0;
    else if (forceMin)  heldWord <= '0;
    else if (!loadHold) heldWord <= ctrlWord;
  end

  // Overrides sit ahead of the chain; the minimum override has priority
  always_comb begin
    if (forceMin)      takeMask = '0;
    else if (forceMax) takeMask = '1;
    else               takeMask = heldWord;
    strobe.extraOn = forceMax & ~forceMin;
    strobe.outEn   = ~enN;
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (loadHold && !forceMin) |=> $stable(heldWord)); // R3
  AST_OPEN_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (!loadHold && !forceMin) |=> (heldWord == $past(ctrlWord))); // R3
  AST_MIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    forceMin |=> (heldWord == '0)); // R4
endmodule

// File: rtl/dly_chain.sv
module dly_chain
  import dly_pkg::*;
#(
  parameter int STAGES = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dataIn,
  input  logic [STAGES-1:0] takeMask,
  input  dlyStrobe_t        strobe,
  output logic              dataOut
);
  localparam int NODES = STAGES + 1;

  logic [NODES-1:0] node;
  logic             tailOut;

  assign node[0] = dataIn;

  // Weighted stages in series, largest weight first
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      localparam int BITIDX = STAGES - 1 - i;
      dly_stage #(.DEPTH(1 << BITIDX)) stage_i (
        .clk  (clk),
        .rst  (rst),
        .take (takeMask[BITIDX]),
        .din  (node[i]),
        .dout (node[i+1])
      );
    end
  endgenerate

  // Extra unit stage, used only by the maximum override
  dly_stage #(.DEPTH(1)) extra_i (
    .clk  (clk),
    .rst  (rst),
    .take (strobe.extraOn),
    .din  (node[STAGES]),
    .dout (tailOut)
  );

  always_ff @(posedge clk) begin
    if (rst) dataOut <= 1'b0;
    else     dataOut <= strobe.outEn ? tailOut : 1'b0;
  end

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !strobe.outEn |=> (dataOut == 1'b0)); // R7
  AST_EXTRA_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    strobe.extraOn |-> (&takeMask)); // R5
endmodule

// File: rtl/dly_line_top.sv
module dly_line_top
  import dly_pkg::*;
#(
  parameter int STAGES = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dataIn,
  input  logic [STAGES-1:0] ctrlWord,
  input  logic              loadHold,
  input  logic              forceMin,
  input  logic              forceMax,
  input  logic              enN,
  output logic              dataOut
);
  logic [STAGES-1:0] takeMask;
  dlyStrobe_t        strobe;

  dly_ctrl #(.STAGES(STAGES)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .ctrlWord (ctrlWord),
    .loadHold (loadHold),
    .forceMin (forceMin),
    .forceMax (forceMax),
    .enN      (enN),
    .takeMask (takeMask),
    .strobe   (strobe)
  );

  dly_chain #(.STAGES(STAGES)) chain_i (
    .clk      (clk),
    .rst      (rst),
    .dataIn   (dataIn),
    .takeMask (takeMask),
    .strobe   (strobe),
    .dataOut  (dataOut)
  );

  AST_MIN_WINS: assert property (@(posedge clk) disable iff (rst)
    (forceMin && forceMax) |-> (takeMask == '0 && !strobe.extraOn)); // R6
endmodule

// File: tb/dly_line_top_tb_top.sv
module dly_line_top_tb_top;
  localparam int STG   = 4;
  localparam int MAXD  = 1 << STG;
  localparam int FLUSH = 2 * MAXD + 4;
  localparam int WIN   = 20;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           dataIn = 1'b0;
  logic [STG-1:0] ctrlWord = '0;
  logic           loadHold = 1'b0;
  logic           forceMin = 1'b0;
  logic           forceMax = 1'b0;
  logic           enN = 1'b0;
  logic           dataOut;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic hist [0:63];

  always #2 clk = ~clk;

  dly_line_top #(.STAGES(STG)) dut_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .ctrlWord(ctrlWord),
    .loadHold(loadHold), .forceMin(forceMin), .forceMax(forceMax),
    .enN(enN), .dataOut(dataOut)
  );

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, got, exp);
    end
  endtask

  // n cycles of random data; compare against delay dly+1 when doChk
  task automatic run(int n, bit doChk, int dly, bit forceZero, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (doChk)
        chk(tag, dataOut, forceZero ? 1'b0 : hist[(cyc - 1 - dly) & 63]);
      dataIn = 1'($urandom % 2);
      hist[cyc & 63] = dataIn;
      cyc++;
    end
  endtask

  task automatic settleCheck(int dly, string tag);
    run(FLUSH, 1'b0, 0, 1'b0, tag);
    run(WIN, 1'b1, dly, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) hist[i] = 1'b0;
    // R8: reset with a word on the pins and the hold closed
    ctrlWord = 4'd5;
    loadHold = 1'b1;
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 reset output", dataOut, 1'b0);
      dataIn = 1'($urandom % 2);
      hist[cyc & 63] = dataIn;
      cyc++;
    end
    rst = 1'b0;
    settleCheck(0, "R8 held word cleared");

    // R1/R2: sweep every control word
    loadHold = 1'b0;
    for (int w = 0; w < MAXD; w++) begin
      ctrlWord = STG'(w);
      settleCheck(w, "R1 R2 word sweep");
    end

    // R3: hold closes on 3, later words ignored; reopen picks up 12
    ctrlWord = 4'd3;
    settleCheck(3, "R3 open");
    loadHold = 1'b1;
    ctrlWord = 4'd12;
    settleCheck(3, "R3 held");
    loadHold = 1'b0;
    settleCheck(12, "R3 reopened");

    // R4: minimum override and clearing of the held word
    ctrlWord = 4'd9;
    settleCheck(9, "R4 before");
    forceMin = 1'b1;
    settleCheck(0, "R4 forced");
    loadHold = 1'b1;
    run(2, 1'b0, 0, 1'b0, "R4");
    forceMin = 1'b0;
    settleCheck(0, "R4 cleared while held");
    loadHold = 1'b0;
    settleCheck(9, "R4 reload");

    // R5: maximum override ignores both the pins and the held word
    ctrlWord = 4'd2;
    forceMax = 1'b1;
    settleCheck(MAXD, "R5 forced max");
    loadHold = 1'b1;
    ctrlWord = 4'd7;
    settleCheck(MAXD, "R5 forced max held");
    forceMax = 1'b0;
    settleCheck(2, "R5 released");
    loadHold = 1'b0;

    // R6: both overrides, minimum wins
    forceMin = 1'b1;
    forceMax = 1'b1;
    settleCheck(0, "R6 both overrides");
    forceMin = 1'b0;
    forceMax = 1'b0;

    // R7: enable
    ctrlWord = 4'd6;
    settleCheck(6, "R7 enabled");
    enN = 1'b1;
    run(1, 1'b0, 0, 1'b0, "R7");
    run(WIN, 1'b1, 0, 1'b1, "R7 disabled low");
    enN = 1'b0;
    run(1, 1'b0, 0, 1'b0, "R7");
    run(WIN, 1'b1, 6, 1'b0, "R7 re-enabled");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule